// File: doc/BRIEF.md
# Audio Serial Port, Clock Master

This block drives a stereo audio codec over a three-wire serial link and generates every clock of that link itself. A prescaler divides the system clock to produce the codec master clock, and the bit clock and the left/right word select are derived from that master clock. The master clock runs at either 256 or 384 times the sample rate. The bit clock always runs at 32 times the sample rate, so each channel occupies 16 bit periods.

On the transmit side, 16-bit samples from a 32-entry FIFO are shifted out MSB first. The FIFO is filled left, right, left, right. If the FIFO runs dry, the block sends zero samples and latches an underrun flag. On the receive side, the serial input is captured into a second 32-entry FIFO in the same left/right order. Each direction has its own enable, its own DMA request enable and its own FIFO enable. Dropping a FIFO enable flushes that FIFO. Dropping the start input stops the whole link and returns it to the start of a left slot.

Top module: `aud_serial_master`

## Requirements
- R1: While running (`start_i` and `psc_en_i` both high), the prescaler emits one tick every `psc_i`+1 system clocks. `mclk_o` toggles on every tick, so its period is 2·(`psc_i`+1) system clocks.
- R2: The bit clock period is 8 `mclk_o` periods when `mclk384_i`=0 (256fs) and 12 when `mclk384_i`=1 (384fs).
- R3: `ws_o` is low for the left channel and high for the right channel. It changes only when `bclk_o` falls. Each level lasts exactly 16 bit clocks.
- R4: `sdo_o` changes only when `bclk_o` falls. The MSB of each word appears in the bit period after the `ws_o` edge. Each transmitted word's LSB falls in the first bit period of the following channel. Words leave in FIFO order, the first word going to the left channel.
- R5: `sdi_i` is sampled when `bclk_o` rises, MSB first, with the same slot alignment as R4. Completed words are pushed left first, then right, and `rx_rdata_o` shows the oldest one.
- R6: If a transmit word is due and the transmit FIFO is empty, a zero word is sent and `underrun_o` is set. `underrun_o` stays set until `tx_fifo_en_i` is low.
- R7: `tx_dreq_o` is high exactly when `tx_dma_en_i`, `tx_en_i` and `tx_fifo_en_i` are all high and `tx_full_o` is low.
- R8: `rx_dreq_o` is high exactly when `rx_dma_en_i`, `rx_en_i` and `rx_fifo_en_i` are all high and `rx_empty_o` is low.
- R9: A FIFO whose enable is low is held empty one cycle later. Writes to it are ignored, and reads from it are ignored.
- R10: While not running, `mclk_o`, `bclk_o`, `ws_o` and `sdo_o` are low one cycle later. A new start begins at the left slot.
- R11: With `tx_en_i` low, `sdo_o` stays low and the transmit FIFO is not popped. With `rx_en_i` low, nothing is pushed.
- R12: After reset all clock outputs, `sdo_o`, the DMA requests and `underrun_o` are low, `rx_empty_o` is high and `tx_full_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run the link; low stops it |
| psc_en_i | input | 1 | Prescaler enable |
| psc_i | input | PSC_W | Prescaler value N, divide by N+1 |
| mclk384_i | input | 1 | 1: master clock 384fs, 0: 256fs |
| tx_en_i | input | 1 | Transmit path active |
| rx_en_i | input | 1 | Receive path active |
| tx_dma_en_i | input | 1 | Transmit DMA request enable |
| rx_dma_en_i | input | 1 | Receive DMA request enable |
| tx_fifo_en_i | input | 1 | Transmit FIFO enable; low flushes |
| rx_fifo_en_i | input | 1 | Receive FIFO enable; low flushes |
| tx_wr_i | input | 1 | Write `tx_wdata_i` into the transmit FIFO |
| tx_wdata_i | input | 16 | Transmit sample |
| tx_full_o | output | 1 | Transmit FIFO full |
| rx_rd_i | input | 1 | Pop the receive FIFO |
| rx_rdata_o | output | 16 | Oldest received sample |
| rx_empty_o | output | 1 | Receive FIFO empty |
| tx_dreq_o | output | 1 | Transmit DMA request |
| rx_dreq_o | output | 1 | Receive DMA request |
| underrun_o | output | 1 | Sticky transmit underrun |
| mclk_o | output | 1 | Codec master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
The transmit path is driven with word pairs that place a single set bit at the MSB and at the LSB, all ones, all zeros, alternating patterns and asymmetric values. These patterns separate a wrong bit order, an off-by-one slot alignment and a left/right swap. The same table is played into the serial input, which tests the receive alignment independently of the transmit side. The FIFO is then drained past its end, so the transmitted zeros and the sticky underrun flag can be told apart from a stalled shifter. The clock periods are measured at both master clock ratios and two prescaler values, and the measurements tell the 256fs and 384fs dividers apart from the prescaler.

// File: rtl/aud_pkg.sv
package aud_pkg;
  localparam int SAMPLE_W = 16;
  localparam int SLOTS    = 2 * SAMPLE_W;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int HALF_256 = 8;   // prescaler ticks per bit-clock half, 256fs
  localparam int HALF_384 = 12;  // prescaler ticks per bit-clock half, 384fs
  localparam int HC_W     = $clog2(HALF_384);
  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [SLOT_W-1:0]   slot_t;
endpackage

// File: rtl/aud_fifo.sv
module aud_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q;
  logic         do_push, do_pop;

  assign empty_o = (wp_q == rp_q);
  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign do_push = en_i && push_i && !full_o;
  assign do_pop  = en_i && pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else if (!en_i) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + (AW+1)'(1);
      if (do_pop)  rp_q <= rp_q + (AW+1)'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q[AW-1:0]] <= wdata_i;
  end

  assign rdata_o = mem[rp_q[AW-1:0]];
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_pkg::*;
#(
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             mclk384_i,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             rise_o,
  output logic             fall_o,
  output slot_t            slot_o
);
  logic [PSC_W-1:0] psc_q;
  logic [HC_W-1:0]  half_q, half_lim;
  logic             tick, bedge, mclk_q, bclk_q;
  slot_t            slot_q;

  assign tick     = run_i && (psc_q >= psc_i);
  assign half_lim = mclk384_i ? HC_W'(HALF_384 - 1) : HC_W'(HALF_256 - 1);
  assign bedge    = tick && (half_q >= half_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q  <= '0;
      half_q <= '0;
      mclk_q <= 1'b0;
      bclk_q <= 1'b0;
      slot_q <= '0;
    end else if (!run_i) begin
      psc_q  <= '0;
      half_q <= '0;
      mclk_q <= 1'b0;
      bclk_q <= 1'b0;
      slot_q <= '0;
    end else begin
      psc_q <= tick ? '0 : psc_q + PSC_W'(1);
      if (tick) begin
        mclk_q <= ~mclk_q;
        half_q <= bedge ? '0 : half_q + HC_W'(1);
      end
      if (bedge) begin
        bclk_q <= ~bclk_q;
        if (bclk_q) slot_q <= slot_q + SLOT_W'(1);
      end
    end
  end

  assign mclk_o = mclk_q;
  assign bclk_o = bclk_q;
  assign ws_o   = slot_q[SLOT_W-1];
  assign rise_o = bedge && !bclk_q;
  assign fall_o = bedge && bclk_q;
  assign slot_o = slot_q;
endmodule

// File: rtl/aud_shifter.sv
module aud_shifter
  import aud_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    run_i,
  input  logic    tx_en_i,
  input  logic    rx_en_i,
  input  logic    rise_i,
  input  logic    fall_i,
  input  slot_t   slot_i,
  input  logic    sdi_i,
  output logic    sdo_o,
  input  logic    tx_empty_i,
  input  sample_t tx_head_i,
  output logic    tx_pop_o,
  output logic    underrun_set_o,
  output logic    rx_push_o,
  output sample_t rx_wdata_o
);
  slot_t   nxt_slot;
  sample_t tx_sh_q, word, rx_sh_q;
  logic    load, sdo_q, seen_left_q, rx_bit, left_done, right_done;

  // transmit: load on the fall that enters the first bit slot of each channel
  assign nxt_slot       = slot_i + SLOT_W'(1);
  assign load           = fall_i && tx_en_i &&
                          (nxt_slot == SLOT_W'(1) || nxt_slot == SLOT_W'(SAMPLE_W + 1));
  assign word           = tx_empty_i ? '0 : tx_head_i;
  assign tx_pop_o       = load && !tx_empty_i;
  assign underrun_set_o = load && tx_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q <= '0;
      sdo_q   <= 1'b0;
    end else if (!run_i || !tx_en_i) begin
      tx_sh_q <= '0;
      sdo_q   <= 1'b0;
    end else if (fall_i) begin
      if (load) begin
        sdo_q   <= word[SAMPLE_W-1];
        tx_sh_q <= {word[SAMPLE_W-2:0], 1'b0};
      end else begin
        sdo_q   <= tx_sh_q[SAMPLE_W-1];
        tx_sh_q <= {tx_sh_q[SAMPLE_W-2:0], 1'b0};
      end
    end
  end

  assign sdo_o = sdo_q;

  // receive: a channel's last bit lands in the first slot of the next channel
  assign rx_bit     = run_i && rx_en_i && rise_i;
  assign left_done  = rx_bit && (slot_i == SLOT_W'(SAMPLE_W));
  assign right_done = rx_bit && (slot_i == '0) && seen_left_q;
  assign rx_push_o  = left_done || right_done;
  assign rx_wdata_o = {rx_sh_q[SAMPLE_W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh_q     <= '0;
      seen_left_q <= 1'b0;
    end else if (!run_i || !rx_en_i) begin
      rx_sh_q     <= '0;
      seen_left_q <= 1'b0;
    end else if (rx_bit) begin
      rx_sh_q <= rx_wdata_o;
      if (left_done) seen_left_q <= 1'b1;
    end
  end
endmodule

// File: rtl/aud_serial_master.sv
module aud_serial_master
  import aud_pkg::*;
#(
  parameter int PSC_W      = 8,
  parameter int FIFO_DEPTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             psc_en_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             mclk384_i,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic             tx_dma_en_i,
  input  logic             rx_dma_en_i,
  input  logic             tx_fifo_en_i,
  input  logic             rx_fifo_en_i,
  input  logic             tx_wr_i,
  input  logic [15:0]      tx_wdata_i,
  output logic             tx_full_o,
  input  logic             rx_rd_i,
  output logic [15:0]      rx_rdata_o,
  output logic             rx_empty_o,
  output logic             tx_dreq_o,
  output logic             rx_dreq_o,
  output logic             underrun_o,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             sdo_o,
  input  logic             sdi_i
);
  logic    run, rise, fall, tx_empty, tx_pop, urun_set, rx_push, urun_q;
  slot_t   slot;
  sample_t tx_head, rx_wdata;

  assign run = start_i && psc_en_i;

  aud_clkgen #(.PSC_W(PSC_W)) u_clkgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .psc_i     (psc_i),
    .mclk384_i (mclk384_i),
    .mclk_o    (mclk_o),
    .bclk_o    (bclk_o),
    .ws_o      (ws_o),
    .rise_o    (rise),
    .fall_o    (fall),
    .slot_o    (slot)
  );

  aud_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tx_fifo_en_i),
    .push_i  (tx_wr_i),
    .wdata_i (tx_wdata_i),
    .pop_i   (tx_pop),
    .rdata_o (tx_head),
    .full_o  (tx_full_o),
    .empty_o (tx_empty)
  );

  aud_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rx_fifo_en_i),
    .push_i  (rx_push),
    .wdata_i (rx_wdata),
    .pop_i   (rx_rd_i),
    .rdata_o (rx_rdata_o),
    .full_o  (),
    .empty_o (rx_empty_o)
  );

  aud_shifter u_shifter (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .run_i          (run),
    .tx_en_i        (tx_en_i),
    .rx_en_i        (rx_en_i),
    .rise_i         (rise),
    .fall_i         (fall),
    .slot_i         (slot),
    .sdi_i          (sdi_i),
    .sdo_o          (sdo_o),
    .tx_empty_i     (tx_empty),
    .tx_head_i      (tx_head),
    .tx_pop_o       (tx_pop),
    .underrun_set_o (urun_set),
    .rx_push_o      (rx_push),
    .rx_wdata_o     (rx_wdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            urun_q <= 1'b0;
    else if (!tx_fifo_en_i) urun_q <= 1'b0;
    else if (urun_set)      urun_q <= 1'b1;
  end

  assign underrun_o = urun_q;
  assign tx_dreq_o  = tx_dma_en_i && tx_en_i && tx_fifo_en_i && !tx_full_o;
  assign rx_dreq_o  = rx_dma_en_i && rx_en_i && rx_fifo_en_i && !rx_empty_o;
endmodule

// File: rtl/aud_serial_master_chk.sv
module aud_serial_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic psc_en_i,
  input logic tx_en_i,
  input logic tx_fifo_en_i,
  input logic rx_fifo_en_i,
  input logic tx_full_o,
  input logic rx_empty_o,
  input logic tx_dreq_o,
  input logic rx_dreq_o,
  input logic underrun_o,
  input logic mclk_o,
  input logic bclk_o,
  input logic ws_o,
  input logic sdo_o
);
  logic run;
  assign run = start_i && psc_en_i;

  // R3
  ws_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run) && !$stable(ws_o)) |-> $fell(bclk_o));

  // R4
  sdo_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run) && tx_en_i && $past(tx_en_i) && !$stable(sdo_o)) |-> $fell(bclk_o));

  // R6
  underrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && tx_fifo_en_i) |=> underrun_o);

  // R7
  tx_dreq_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_o |-> !tx_dreq_o);

  // R8
  rx_dreq_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> !rx_dreq_o);

  // R9
  tx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_fifo_en_i |=> !tx_full_o);

  // R9
  rx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_fifo_en_i |=> rx_empty_o);

  // R10
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (!mclk_o && !bclk_o && !ws_o && !sdo_o));

  // R11
  tx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !sdo_o);
endmodule

bind aud_serial_master aud_serial_master_chk u_chk (.*);

// File: tb/aud_serial_master_tb.sv
module aud_serial_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h8000, 16'h0001, 16'hFFFF, 16'h0000, 16'hA5A5, 16'h5A5A,
    16'h1234, 16'hFEDC, 16'h7FFF, 16'h8001, 16'h00FF, 16'hFF00};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, psc_en = 0, mclk384 = 0, tx_en = 0, rx_en = 0;
  logic tx_dma_en = 0, rx_dma_en = 0, tx_fifo_en = 0, rx_fifo_en = 0;
  logic tx_wr = 0, rx_rd = 0, sdi = 0;
  logic [7:0]  psc = 8'd0;
  logic [15:0] tx_wdata = 16'h0, rx_rdata;
  logic tx_full, rx_empty, tx_dreq, rx_dreq, underrun, mclk, bclk, ws, sdo;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // codec model state
  logic [15:0] cap_sh, cap_words [64];
  int cap_n, slot_m, pair_m, phase_rises, bad_phase, sdo_idle_hi;
  int cyc = 0, mclk_last, bclk_last, mclk_per, bclk_per;
  logic bclk_prev = 0, mclk_prev = 0, ws_prev = 0, start_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_serial_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .psc_en_i(psc_en), .psc_i(psc),
    .mclk384_i(mclk384), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .tx_dma_en_i(tx_dma_en), .rx_dma_en_i(rx_dma_en),
    .tx_fifo_en_i(tx_fifo_en), .rx_fifo_en_i(rx_fifo_en),
    .tx_wr_i(tx_wr), .tx_wdata_i(tx_wdata), .tx_full_o(tx_full),
    .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata), .rx_empty_o(rx_empty),
    .tx_dreq_o(tx_dreq), .rx_dreq_o(rx_dreq), .underrun_o(underrun),
    .mclk_o(mclk), .bclk_o(bclk), .ws_o(ws), .sdo_o(sdo), .sdi_i(sdi));

  // codec model: samples on bit clock rise, drives on bit clock fall
  always @(negedge clk) begin
    cyc++;
    if (start && !start_prev) begin
      cap_sh = '0; cap_n = 0; slot_m = 0; pair_m = -1; phase_rises = 0;
      bad_phase = 0; sdo_idle_hi = 0; ws_prev = 0; sdi = 0;
      mclk_last = cyc; bclk_last = cyc; mclk_per = 0; bclk_per = 0;
    end
    if (start && !tx_en && sdo) sdo_idle_hi++;
    if (mclk && !mclk_prev) begin mclk_per = cyc - mclk_last; mclk_last = cyc; end
    if (bclk && !bclk_prev) begin
      bclk_per = cyc - bclk_last; bclk_last = cyc;
      cap_sh = {cap_sh[14:0], sdo};
      if (ws != ws_prev) begin
        if (phase_rises != 16) bad_phase++;
        phase_rises = 1;
        if (cap_n < 64) cap_words[cap_n] = cap_sh;
        cap_n++;
      end else phase_rises++;
      ws_prev = ws;
    end
    if (!bclk && bclk_prev) begin
      slot_m = (slot_m + 1) % 32;
      if (slot_m == 1) pair_m++;
      if (pair_m < 0) sdi = 0;
      else if (slot_m >= 1 && slot_m <= 16) sdi = VEC[2*(pair_m%6)][16-slot_m];
      else if (slot_m == 0) sdi = VEC[2*(pair_m%6)+1][0];
      else sdi = VEC[2*(pair_m%6)+1][32-slot_m];
    end
    bclk_prev = bclk; mclk_prev = mclk; start_prev = start;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [15:0] d);
    @(negedge clk); tx_wr = 1; tx_wdata = d;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk({mclk, bclk, ws, sdo} == 4'b0, "R12 clocks/sdo", {mclk, bclk, ws, sdo}, 0);
    chk({tx_dreq, rx_dreq, underrun} == 3'b0, "R12 dreq/underrun", {tx_dreq, rx_dreq, underrun}, 0);
    chk(rx_empty && !tx_full, "R12 fifo flags", {rx_empty, tx_full}, 2'b10);

    // R7 / R9: fill, flush, ignored writes
    tx_fifo_en = 1; tx_en = 1; tx_dma_en = 1;
    @(negedge clk);
    chk(tx_dreq, "R7 dreq when room", tx_dreq, 1);
    for (int i = 0; i < 32; i++) push_tx(16'(i));
    chk(tx_full, "R9 full after 32", tx_full, 1);
    chk(!tx_dreq, "R7 no dreq when full", tx_dreq, 0);
    tx_dma_en = 0;
    tx_fifo_en = 0; @(negedge clk); @(negedge clk);
    chk(!tx_full, "R9 flush empties", tx_full, 0);
    chk(!tx_dreq, "R7 no dreq with dma off", tx_dreq, 0);
    push_tx(16'h1111);                       // ignored: FIFO disabled
    tx_fifo_en = 1; tx_dma_en = 1;
    for (int i = 0; i < 31; i++) push_tx(16'h2222);
    chk(!tx_full, "R9 write while disabled ignored", tx_full, 0);
    tx_en = 0; @(negedge clk);
    chk(!tx_dreq, "R7 no dreq when tx idle", tx_dreq, 0);
    tx_en = 1;
    tx_fifo_en = 0; @(negedge clk); tx_fifo_en = 1;

    // vector table: transmit at 256fs, N=0
    for (int i = 0; i < NVEC; i++) push_tx(VEC[i]);
    psc = 0; mclk384 = 0;
    @(negedge clk); start = 1; psc_en = 1;
    repeat (4400) @(negedge clk);
    chk(cap_n >= 16, "R4 words captured", cap_n, 16);
    for (int i = 0; i < NVEC; i++)
      chk(cap_words[i] == VEC[i], $sformatf("R4 tx word %0d", i), cap_words[i], VEC[i]);
    for (int i = NVEC; i < 16; i++)
      chk(cap_words[i] == 16'h0, "R6 underrun sends zero", cap_words[i], 0);
    chk(underrun, "R6 underrun flag", underrun, 1);
    chk(bad_phase == 0, "R3 16 bits per ws level", bad_phase, 0);
    chk(mclk_per == 2, "R1 mclk period N=0", mclk_per, 2);
    chk(bclk_per == 16, "R2 bclk period 256fs", bclk_per, 16);
    start = 0; @(negedge clk);
    chk({mclk, bclk, ws, sdo} == 4'b0, "R10 stop quiets link", {mclk, bclk, ws, sdo}, 0);
    chk(underrun, "R6 still sticky", underrun, 1);
    tx_fifo_en = 0; @(negedge clk);
    chk(!underrun, "R6 flush clears flag", underrun, 1'b0);

    // receive at 384fs, N=1, transmit idle
    tx_en = 0; rx_en = 1; rx_fifo_en = 1; rx_dma_en = 1; psc = 1; mclk384 = 1;
    @(negedge clk); start = 1;
    repeat (7000) @(negedge clk);
    chk(mclk_per == 4, "R1 mclk period N=1", mclk_per, 4);
    chk(bclk_per == 48, "R2 bclk period 384fs", bclk_per, 48);
    chk(sdo_idle_hi == 0, "R11 sdo low while tx idle", sdo_idle_hi, 0);
    chk(bad_phase == 0, "R3 ws phase 384fs", bad_phase, 0);
    chk(rx_dreq, "R8 dreq when data", rx_dreq, 1);
    start = 0; @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      chk(!rx_empty, "R5 data available", rx_empty, 0);
      chk(rx_rdata == VEC[i], $sformatf("R5 rx word %0d", i), rx_rdata, VEC[i]);
      rx_rd = 1; @(negedge clk); rx_rd = 0;
    end
    rx_dma_en = 0; @(negedge clk);
    chk(!rx_dreq, "R8 no dreq with dma off", rx_dreq, 0);
    rx_fifo_en = 0; @(negedge clk);
    chk(rx_empty, "R9 rx flush", rx_empty, 1);

    done = 1;
    finish_run();
  end
endmodule